// File: doc/BRIEF.md
# Protected System Reset Controller

This block is the register-mapped reset hub of a chip. Software reaches it over a simple 32-bit register bus: an address, a write strobe, write data and combinational read data. Through it, software can fire short reset pulses at the whole chip or at the CPU kernel. It can also hold the DMA engine in reset, and hold any of thirteen peripherals in reset. The two one-shot pulse bits are guarded by a lock. Software opens the lock by writing a three-byte key to the lock register. Any later write to that register closes it again.

The block also keeps a record of why the chip was last reset. Hardware pulses from the power-on detector, the reset pin, the power manager, the watchdog and the software system-reset request each set a sticky flag. A CPU one-shot reset sets a flag as well. Firmware reads these flags after start-up and clears each one by writing 1 to its bit. The flags survive a chip one-shot reset. That reset returns the lock, the DMA bit and the peripheral word to zero.

Top module: `sys_rst_ctrl`

## Requirements
- R1: After reset the lock register (offset 0x100) reads 0 in bit 0. Three writes to it whose low byte is 0x59, then 0x16, then 0x88 make bit 0 read 1. Writes to other offsets do not disturb the sequence. A wrong byte restarts the sequence, and a wrong byte of 0x59 counts as the first key byte. Any write to the lock register while it reads 1 makes it read 0.
- R2: While locked, writing 1 to bit 0 (chip) or bit 1 (CPU) of the control word at offset 0x8 is ignored. Both outputs stay low and both bits read 0.
- R3: While unlocked, writing 1 to control bit 0 raises chip_rst and makes that bit read 1. This starts on the clock edge that takes the write, and lasts for exactly two cycles. Then both return to 0 by themselves.
- R4: While unlocked, writing 1 to control bit 1 raises cpu_rst and makes that bit read 1 for exactly two cycles, in the same way as R3. On the same edge it also sets bit 7 of the reset-source register.
- R5: Control bit 2 is not protected. It holds the value last written to it, and dma_rst follows it whether the lock is open or closed.
- R6: The peripheral word at offset 0xC is read/write at bits 6, 7, 8, 12, 13, 16, 18, 19, 20, 22, 28, 29 and 30, and periph_rst equals the word. All its other bits read 0 and ignore writes.
- R7: The reset-source register at offset 0x4 is set one edge after an event pulse, as follows. ev_por or ev_pin sets bit 0. ev_pmu sets bits 0 and 6. ev_wdt sets bit 2. ev_sysreq sets bit 5. Its other bits read 0.
- R8: Writing 1 to a reset-source bit clears that bit. Writing 0 leaves it unchanged.
- R9: When an event sets a reset-source bit on the same edge that software writes 1 to clear it, the bit ends up set.
- R10: When a chip one-shot pulse ends, the lock closes and the DMA bit and the peripheral word become 0. The reset-source flags keep their values.
- R11: Every offset other than 0x4, 0x8, 0xC and 0x100 reads 0. Unimplemented bits of the control and lock words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears every register |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ev_por | input | 1 | Power-on reset event pulse |
| ev_pin | input | 1 | Reset pin event pulse |
| ev_pmu | input | 1 | Power manager reset event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_sysreq | input | 1 | Software system-reset request pulse |
| chip_rst | output | 1 | Whole-chip reset, one-shot |
| cpu_rst | output | 1 | CPU kernel reset, one-shot |
| dma_rst | output | 1 | DMA engine reset, level |
| periph_rst | output | 32 | Per-peripheral reset lines |

## Verification
Two things can land on one reset-source bit on the same clock edge: a hardware event that sets the bit, and a software write of 1 that clears it. The bench provokes this by raising ev_wdt and writing 1 to bit 2 of offset 0x4 on the same edge. It then reads the register on the next cycle and expects bit 2 to be set. A separate clear with no event present confirms that the set really came from the collision and was not left over. A second overlap occurs between the ending of a chip pulse and the state it wipes. The bench judges this by reading the lock, control, peripheral and reset-source words right after the pulse ends.

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PULSE_CYC = 2,
  parameter logic [31:0] PERIPH_MASK = 32'h705D_31C0,
  parameter logic [7:0] KEY0 = 8'h59,
  parameter logic [7:0] KEY1 = 8'h16,
  parameter logic [7:0] KEY2 = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_por,
  input  logic              ev_pin,
  input  logic              ev_pmu,
  input  logic              ev_wdt,
  input  logic              ev_sysreq,
  output logic              chip_rst,
  output logic              cpu_rst,
  output logic              dma_rst,
  output logic [DATA_W-1:0] periph_rst
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [ADDR_W-1:0] OFS_SRC  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_PER  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_LOCK = ADDR_W'(12'h100);
  localparam logic [7:0] SRC_MASK = 8'hE5;

  logic [1:0]        key_st;
  logic              unlocked;
  logic [CW-1:0]     chip_cnt, cpu_cnt;
  logic              dma_q;
  logic [DATA_W-1:0] per_q;
  logic [7:0]        flags_q;

  wire wr_src  = wr_en && addr == OFS_SRC;
  wire wr_ctl  = wr_en && addr == OFS_CTL;
  wire wr_per  = wr_en && addr == OFS_PER;
  wire wr_lock = wr_en && addr == OFS_LOCK;
  wire [7:0] wbyte = wdata[7:0];
  wire [1:0] restart = (wbyte == KEY0) ? 2'd1 : 2'd0;

  wire chip_go   = wr_ctl && unlocked && wdata[0];
  wire cpu_go    = wr_ctl && unlocked && wdata[1];
  wire chip_done = chip_cnt == CW'(1) && !chip_go;

  wire [7:0] flag_set = {cpu_go, ev_pmu, ev_sysreq, 2'b00, ev_wdt, 1'b0,
                         ev_por | ev_pin | ev_pmu};
  wire [7:0] flag_clr = wr_src ? wbyte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st   <= 2'd0;
      unlocked <= 1'b0;
    end else if (chip_done) begin
      key_st   <= 2'd0;
      unlocked <= 1'b0;
    end else if (wr_lock) begin
      if (unlocked) begin
        unlocked <= 1'b0;
        key_st   <= 2'd0;
      end else begin
        case (key_st)
          2'd0:    key_st <= restart;
          2'd1:    key_st <= (wbyte == KEY1) ? 2'd2 : restart;
          default: begin
            if (wbyte == KEY2) begin
              unlocked <= 1'b1;
              key_st   <= 2'd0;
            end else begin
              key_st   <= restart;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_cnt <= '0;
      cpu_cnt  <= '0;
    end else begin
      if (chip_go) chip_cnt <= CW'(PULSE_CYC);
      else if (chip_cnt != '0) chip_cnt <= chip_cnt - CW'(1);
      if (cpu_go) cpu_cnt <= CW'(PULSE_CYC);
      else if (cpu_cnt != '0) cpu_cnt <= cpu_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= 1'b0;
      per_q <= '0;
    end else if (chip_done) begin
      dma_q <= 1'b0;
      per_q <= '0;
    end else begin
      if (wr_ctl) dma_q <= wdata[2];
      if (wr_per) per_q <= wdata & DATA_W'(PERIPH_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= ((flags_q & ~flag_clr) | flag_set) & SRC_MASK;
  end

  assign chip_rst   = chip_cnt != '0;
  assign cpu_rst    = cpu_cnt != '0;
  assign dma_rst    = dma_q;
  assign periph_rst = per_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_SRC:  rdata[7:0] = flags_q;
      OFS_CTL:  rdata[2:0] = {dma_q, cpu_rst, chip_rst};
      OFS_PER:  rdata = per_q;
      OFS_LOCK: rdata[0] = unlocked;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sys_rst_ctrl_chk.sv
module sys_rst_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ev_wdt,
  input logic              chip_rst,
  input logic              cpu_rst,
  input logic              unlocked,
  input logic [7:0]        flags_q
);
  wire ctl_wr  = wr_en && addr == ADDR_W'(12'h008);
  wire src_wr  = wr_en && addr == ADDR_W'(12'h004);

  // R2
  locked_chip_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !chip_rst) |=> !chip_rst);

  // R2
  locked_cpu_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !cpu_rst) |=> !cpu_rst);

  // R3
  chip_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |=> chip_rst);

  // R3
  chip_max_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && $past(chip_rst) && !(ctl_wr && wdata[0])) |=> !chip_rst);

  // R4
  cpu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> flags_q[7]);

  // R8
  flag_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(src_wr));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt && src_wr && wdata[2]) |=> flags_q[2]);
endmodule

bind sys_rst_ctrl sys_rst_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ev_wdt(ev_wdt), .chip_rst(chip_rst), .cpu_rst(cpu_rst),
  .unlocked(unlocked), .flags_q(flags_q)
);

// File: tb/test_sys_rst_ctrl.sv
module test_sys_rst_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ev_por = 0, ev_pin = 0, ev_pmu = 0, ev_wdt = 0, ev_sysreq = 0;
  logic chip_rst, cpu_rst, dma_rst;
  logic [31:0] periph_rst;
  int pass_n = 0;
  int tot_n = 0;
  logic [31:0] pmask;

  always #2.5 clk = ~clk;

  sys_rst_ctrl i_sys_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_por(ev_por), .ev_pin(ev_pin), .ev_pmu(ev_pmu),
    .ev_wdt(ev_wdt), .ev_sysreq(ev_sysreq), .chip_rst(chip_rst),
    .cpu_rst(cpu_rst), .dma_rst(dma_rst), .periph_rst(periph_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tot_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #0.5;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: ev_por = 1; 1: ev_pin = 1; 2: ev_pmu = 1; 3: ev_wdt = 1; default: ev_sysreq = 1;
    endcase
    @(negedge clk);
    ev_por = 0; ev_pin = 0; ev_pmu = 0; ev_wdt = 0; ev_sysreq = 0;
  endtask

  initial begin
    #750000;
    tot_n++;
    $display("FAIL watchdog actual=%0d expected=done", tot_n);
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end

  initial begin
    int pos [13] = '{6, 7, 8, 12, 13, 16, 18, 19, 20, 22, 28, 29, 30};
    logic [7:0] evexp [5] = '{8'h01, 8'h01, 8'h41, 8'h04, 8'h20};
    pmask = '0;
    foreach (pos[i]) pmask[pos[i]] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R11 reset state
    rd_chk(12'h100, 0, "R1 reset lock");
    rd_chk(12'h004, 0, "R7 reset flags");
    rd_chk(12'h008, 0, "R2 reset ctl");
    rd_chk(12'h00C, 0, "R6 reset periph");
    chk({chip_rst, cpu_rst, dma_rst} == 0 && periph_rst == 0, "R3 reset outputs",
        {chip_rst, cpu_rst, dma_rst}, 0);

    // R11 unmapped offsets
    for (int a = 0; a < 12'h120; a += 4)
      if (a != 4 && a != 8 && a != 12 && a != 12'h100) rd_chk(12'(a), 0, "R11 unmapped");

    // R2 locked writes ignored
    wr(12'h008, 32'h3);
    chk(!chip_rst && !cpu_rst, "R2 locked outputs", {chip_rst, cpu_rst}, 0);
    rd_chk(12'h008, 0, "R2 locked readback");

    // R1 wrong third byte sweep
    for (int v = 0; v < 256; v++) begin
      if (v == 8'h88) continue;
      wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'(v));
      rd_chk(12'h100, 0, "R1 wrong key");
    end
    wr(12'h100, 32'h16); wr(12'h100, 32'h88);
    rd_chk(12'h100, 0, "R1 partial key");
    wr(12'h100, 32'h59); wr(12'h100, 32'h59); wr(12'h100, 32'h16);
    wr(12'h010, 32'h0);
    wr(12'h100, 32'h88);
    rd_chk(12'h100, 1, "R1 restart on 0x59");
    wr(12'h100, 32'h0);
    rd_chk(12'h100, 0, "R1 relock");

    // R3 chip pulse width
    unlock();
    rd_chk(12'h100, 1, "R1 unlock");
    wr(12'h008, 32'h1);
    chk(chip_rst, "R3 cycle1", chip_rst, 1);
    rd_chk(12'h008, 1, "R3 bit read");
    @(negedge clk);
    chk(chip_rst, "R3 cycle2", chip_rst, 1);
    @(negedge clk);
    chk(!chip_rst, "R3 cleared", chip_rst, 0);
    rd_chk(12'h008, 0, "R3 bit cleared");
    rd_chk(12'h100, 0, "R10 lock closed");

    // R4 cpu pulse and flag
    unlock();
    wr(12'h008, 32'h2);
    chk(cpu_rst, "R4 cycle1", cpu_rst, 1);
    rd_chk(12'h004, 32'h80, "R4 flag");
    @(negedge clk);
    chk(cpu_rst, "R4 cycle2", cpu_rst, 1);
    @(negedge clk);
    chk(!cpu_rst, "R4 cleared", cpu_rst, 0);
    rd_chk(12'h008, 0, "R4 bit cleared");
    wr(12'h004, 32'h80);
    rd_chk(12'h004, 0, "R8 clear bit7");

    // R5 DMA level bit regardless of lock
    wr(12'h100, 32'h0);
    wr(12'h008, 32'h4);
    chk(dma_rst, "R5 set", dma_rst, 1);
    repeat (5) @(negedge clk);
    chk(dma_rst, "R5 held", dma_rst, 1);
    rd_chk(12'h008, 32'h4, "R5 read");
    wr(12'h008, 32'h0);
    chk(!dma_rst, "R5 released", dma_rst, 0);

    // R6 peripheral word sweep
    for (int i = 0; i < 32; i++) begin
      wr(12'h00C, 32'(1) << i);
      rd_chk(12'h00C, (32'(1) << i) & pmask, "R6 single bit");
      chk(periph_rst == ((32'(1) << i) & pmask), "R6 output", periph_rst,
          (32'(1) << i) & pmask);
    end
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk(12'h00C, pmask, "R6 all ones");

    // R7 event sweep
    for (int k = 0; k < 5; k++) begin
      pulse(k);
      rd_chk(12'h004, {24'h0, evexp[k]}, "R7 event");
      wr(12'h004, 32'h0);
      rd_chk(12'h004, {24'h0, evexp[k]}, "R8 write zero");
      wr(12'h004, 32'hFF);
      rd_chk(12'h004, 0, "R8 clear");
    end

    // R9 set and clear collide
    pulse(3);
    @(negedge clk);
    ev_wdt = 1; wr_en = 1; addr = 12'h004; wdata = 32'h4;
    @(negedge clk);
    ev_wdt = 0; wr_en = 0;
    rd_chk(12'h004, 32'h4, "R9 set wins");
    wr(12'h004, 32'h4);
    rd_chk(12'h004, 0, "R9 later clear");

    // R10 chip pulse wipes state but keeps flags
    pulse(4); pulse(3);
    wr(12'h008, 32'h4);
    unlock();
    wr(12'h008, 32'h5);
    rd_chk(12'h00C, pmask, "R10 periph before");
    repeat (2) @(negedge clk);
    rd_chk(12'h00C, 0, "R10 periph wiped");
    chk(periph_rst == 0 && !dma_rst, "R10 outputs", {periph_rst[30:0], dma_rst}, 0);
    rd_chk(12'h008, 0, "R10 ctl wiped");
    rd_chk(12'h100, 0, "R10 lock wiped");
    rd_chk(12'h004, 32'h24, "R10 flags kept");

    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end
endmodule